// File: doc/BRIEF.md
# Extended-Carry Integer ALU

This block is the integer execution unit of a small processor core. Each operation takes two operands (`a_i` and `b_i`), a 4-bit operation code, an operand size and the live condition-code word. It returns a masked result, a write-back enable and, for multiplies, the upper half of the 64-bit product together with a write strobe for the separate multiply-overflow register. It also returns the source value that the downstream flag logic uses.

The carry-in rule is unusual. A plain add or subtract takes in the carry flag only while the extend flag is set. Two add variants always take in a chosen flag: one the carry, the other the R flag. Shift amounts use the whole second operand, so a shift by 32 or more gives a defined result instead of wrapping.

The parameter `REG_OUT` selects the output timing. With `REG_OUT=1` the outputs are registered and `valid_o` rises one cycle after `start_i`. With `REG_OUT=0` the outputs are combinational and `valid_o` follows `start_i`.

Top module: `xc_alu`

## Requirements
- R1: The condition-code word carries C at bit 0, X at bit 4 and R at bit 8. ADD (code 0) returns a+b+(C AND X).
- R2: ADDC (code 1) returns a+b+C whatever X holds. ADDR (code 2) returns a+b+R.
- R3: SUB (code 3) returns a-b-(C AND X). NEG (code 4) returns 0-b-(C AND X).
- R4: CMP (code 5) computes the same value as SUB on `result_o`, but `wb_en_o` stays low.
- R5: LSL (code 9) and LSR (code 10) shift `a` by the full unsigned value of `b`. They return zero when b > 31.
- R6: ASR (code 11) shifts `a` right arithmetically by `b`. When b > 31 it returns all ones for a negative `a` and zero otherwise.
- R7: MULS (code 12) and MULU (code 13) form the 64-bit product of the sign-extended or zero-extended operands. The low word goes to `result_o`, the high word to `mof_o`, and `mof_we_o` is high. No other operation raises `mof_we_o`.
- R8: BOUND (code 7) returns `a` when a <= b (unsigned) and `b` otherwise.
- R9: ABS (code 8) returns -b for a negative `b` and `b` otherwise. An input of 0x80000000 returns 0x80000000.
- R10: MOVE (code 6) returns `b`.
- R11: `size_i` of 1 keeps result bits [7:0] and clears the rest. A size of 2 keeps bits [15:0]. Any other value keeps all 32 bits. `mof_o` is never masked.
- R12: `src_o` is ~b for SUB and CMP, and `b` for every other code.
- R13: With `REG_OUT=1` all outputs appear with `valid_o` one cycle after `start_i` and hold while `start_i` is low. `wb_en_o` and `mof_we_o` are high only while `valid_o` is high. With `REG_OUT=0` they appear in the cycle of `start_i`.
- R14: Codes 14 and 15 are reserved. They return a zero result with `wb_en_o` and `mof_we_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request |
| op_i | input | 4 | Operation code |
| size_i | input | 3 | Operand size in bytes |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand (source) |
| ccs_i | input | CCS_W | Condition-code word |
| result_o | output | DATA_W | Masked result |
| wb_en_o | output | 1 | Destination write enable |
| mof_o | output | DATA_W | High product word |
| mof_we_o | output | 1 | Multiply-overflow register write strobe |
| src_o | output | DATA_W | Source value for flag logic |
| valid_o | output | 1 | Output strobe |

## Verification
The bench builds two copies with `DATA_W=32`, one with `REG_OUT=1` and one with `REG_OUT=0`, and drives both with the same operations. The combinational copy is checked in the cycle of each request and the registered copy one cycle later, so both output paths are exercised against the same expected values. The registered copy alone is checked for holding its outputs and lowering its strobes across idle cycles. With a 32-bit width, the shift amounts just above and below 31, the product high words at the sign boundary and the 0x80000000 ABS input can all be driven.

// File: rtl/xc_alu_pkg.sv
`timescale 1ns/1ps
package xc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_ADDR  = 4'd2,
    OP_SUB   = 4'd3,
    OP_NEG   = 4'd4,
    OP_CMP   = 4'd5,
    OP_MOVE  = 4'd6,
    OP_BOUND = 4'd7,
    OP_ABS   = 4'd8,
    OP_LSL   = 4'd9,
    OP_LSR   = 4'd10,
    OP_ASR   = 4'd11,
    OP_MULS  = 4'd12,
    OP_MULU  = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } op_e;

  localparam int unsigned C_BIT = 0;
  localparam int unsigned X_BIT = 4;
  localparam int unsigned R_BIT = 8;
endpackage

// File: rtl/xc_alu_arith.sv
`timescale 1ns/1ps
module xc_alu_arith
  import xc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         x_i,
  input  logic         r_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] ext_c, c_w, r_w;

  assign ext_c = W'(c_i & x_i);
  assign c_w   = W'(c_i);
  assign r_w   = W'(r_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:          res_o = a_i + b_i + ext_c;
      OP_ADDC:         res_o = a_i + b_i + c_w;
      OP_ADDR:         res_o = a_i + b_i + r_w;
      OP_SUB, OP_CMP:  res_o = a_i - b_i - ext_c;
      OP_NEG:          res_o = '0 - b_i - ext_c;
      OP_MOVE:         res_o = b_i;
      OP_BOUND:        res_o = (a_i <= b_i) ? a_i : b_i;
      OP_ABS:          res_o = b_i[W-1] ? ('0 - b_i) : b_i;
      default:         res_o = '0;
    endcase
  end

  // R8: bound never exceeds either operand
  always_comb begin
    if (op_i == OP_BOUND)
      a_r8_bound_min: assert ((res_o <= a_i) && (res_o <= b_i))
        else $error("bound above an operand");
  end
endmodule

// File: rtl/xc_alu_shift.sv
`timescale 1ns/1ps
module xc_alu_shift
  import xc_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned SH_W = $clog2(W);

  logic            big;
  logic [SH_W-1:0] amt;

  assign big = |b_i[W-1:SH_W];
  assign amt = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_LSL:  res_o = big ? '0 : (a_i << amt);
      OP_LSR:  res_o = big ? '0 : (a_i >> amt);
      OP_ASR:  res_o = big ? {W{a_i[W-1]}} : W'($signed(a_i) >>> amt);
      default: res_o = '0;
    endcase
  end

  // R5: oversized logical shifts give zero
  always_comb begin
    if ((op_i == OP_LSL || op_i == OP_LSR) && (b_i > W - 1))
      a_r5_big_shift_zero: assert (res_o == '0) else $error("big shift nonzero");
  end
endmodule

// File: rtl/xc_alu_mul.sv
`timescale 1ns/1ps
module xc_alu_mul #(
  parameter int unsigned W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic [2*W-1:0] ea, eb, prod;

  assign ea   = {{W{signed_i & a_i[W-1]}}, a_i};
  assign eb   = {{W{signed_i & b_i[W-1]}}, b_i};
  assign prod = ea * eb;
  assign lo_o = prod[W-1:0];
  assign hi_o = prod[2*W-1:W];

  // R7: low word is independent of signedness
  always_comb begin
    a_r7_low_word: assert (lo_o == W'(a_i * b_i)) else $error("low product word");
  end
endmodule

// File: rtl/xc_alu.sv
`timescale 1ns/1ps
module xc_alu
  import xc_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CCS_W   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [CCS_W-1:0]  ccs_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] mof_o,
  output logic              mof_we_o,
  output logic [DATA_W-1:0] src_o,
  output logic              valid_o
);
  localparam logic [DATA_W-1:0] MASK_B = DATA_W'({8{1'b1}});
  localparam logic [DATA_W-1:0] MASK_H = DATA_W'({16{1'b1}});

  op_e op;
  assign op = op_e'(op_i);

  logic [DATA_W-1:0] arith_res, shift_res, mul_lo, mul_hi;
  logic              unused_ccs;
  assign unused_ccs = ^ccs_i;

  xc_alu_arith #(.W(DATA_W)) u_arith (
    .op_i (op), .a_i (a_i), .b_i (b_i),
    .c_i  (ccs_i[C_BIT]), .x_i (ccs_i[X_BIT]), .r_i (ccs_i[R_BIT]),
    .res_o(arith_res)
  );

  xc_alu_shift #(.W(DATA_W)) u_shift (
    .op_i (op), .a_i (a_i), .b_i (b_i), .res_o (shift_res)
  );

  xc_alu_mul #(.W(DATA_W)) u_mul (
    .signed_i (op == OP_MULS), .a_i (a_i), .b_i (b_i),
    .lo_o     (mul_lo), .hi_o (mul_hi)
  );

  logic              is_mul, is_shift, is_rsv, wb_c;
  logic [DATA_W-1:0] raw_res, mask, res_c, src_c;

  assign is_mul   = (op == OP_MULS) || (op == OP_MULU);
  assign is_shift = (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR);
  assign is_rsv   = (op == OP_RSV0) || (op == OP_RSV1);
  assign wb_c     = !is_rsv && (op != OP_CMP);
  assign src_c    = (op == OP_SUB || op == OP_CMP) ? ~b_i : b_i;

  always_comb begin
    if (is_mul)        raw_res = mul_lo;
    else if (is_shift) raw_res = shift_res;
    else if (is_rsv)   raw_res = '0;
    else               raw_res = arith_res;
  end

  always_comb begin
    unique case (size_i)
      3'd1:    mask = MASK_B;
      3'd2:    mask = MASK_H;
      default: mask = '1;
    endcase
  end
  assign res_c = raw_res & mask;

  generate
    if (REG_OUT) begin : g_reg
      logic              valid_q, wb_q, mwe_q;
      logic [DATA_W-1:0] res_q, mof_q, src_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q <= 1'b0;
          wb_q    <= 1'b0;
          mwe_q   <= 1'b0;
          res_q   <= '0;
          mof_q   <= '0;
          src_q   <= '0;
        end else begin
          valid_q <= start_i;
          if (start_i) begin
            wb_q  <= wb_c;
            mwe_q <= is_mul;
            res_q <= res_c;
            mof_q <= mul_hi;
            src_q <= src_c;
          end
        end
      end

      assign valid_o  = valid_q;
      assign wb_en_o  = valid_q & wb_q;
      assign mof_we_o = valid_q & mwe_q;
      assign result_o = res_q;
      assign mof_o    = mof_q;
      assign src_o    = src_q;

      a_r4_cmp_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i == 4'd5) |=> (valid_o && !wb_en_o));
      a_r7_mul_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && (op_i == 4'd12 || op_i == 4'd13)) |=> (mof_we_o && valid_o));
      a_r11_byte_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && size_i == 3'd1) |=> (result_o[DATA_W-1:8] == '0));
    end else begin : g_comb
      assign valid_o  = start_i;
      assign wb_en_o  = start_i & wb_c;
      assign mof_we_o = start_i & is_mul;
      assign result_o = res_c;
      assign mof_o    = mul_hi;
      assign src_o    = src_c;
    end
  endgenerate
endmodule

// File: tb/xc_alu_tb.sv
`timescale 1ns/1ps
module xc_alu_tb;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    op = '0;
  logic [2:0]    size = 3'd4;
  logic [W-1:0]  a = '0, b = '0;
  logic [15:0]   ccs = '0;

  logic [W-1:0]  res_r, mof_r, src_r, res_c, mof_c, src_c;
  logic          wb_r, mwe_r, val_r, wb_c, mwe_c, val_c;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xc_alu #(.DATA_W(W), .CCS_W(16), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .ccs_i(ccs), .result_o(res_r), .wb_en_o(wb_r),
    .mof_o(mof_r), .mof_we_o(mwe_r), .src_o(src_r), .valid_o(val_r));

  xc_alu #(.DATA_W(W), .CCS_W(16), .REG_OUT(1'b0)) u_dut_comb (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .size_i(size),
    .a_i(a), .b_i(b), .ccs_i(ccs), .result_o(res_c), .wb_en_o(wb_c),
    .mof_o(mof_c), .mof_we_o(mwe_c), .src_o(src_c), .valid_o(val_c));

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0:        return "R1";
      4'd1, 4'd2:  return "R2";
      4'd3, 4'd4:  return "R3";
      4'd5:        return "R4";
      4'd9, 4'd10: return "R5";
      4'd11:       return "R6";
      4'd12, 4'd13:return "R7";
      4'd7:        return "R8";
      4'd8:        return "R9";
      4'd6:        return "R10";
      default:     return "R14";
    endcase
  endfunction

  function automatic void ref_model(
    input logic [3:0] o, input logic [2:0] sz, input logic [W-1:0] x, y,
    input logic [15:0] cc, output logic [W-1:0] r, output logic w,
    output logic [W-1:0] hi, output logic mw, output logic [W-1:0] s);
    logic [63:0] p;
    logic [W-1:0] ex;
    ex = {31'd0, cc[0] & cc[4]};
    hi = '0; mw = 1'b0; w = 1'b1;
    s = (o == 4'd3 || o == 4'd5) ? ~y : y;
    case (o)
      4'd0:  r = x + y + ex;
      4'd1:  r = x + y + {31'd0, cc[0]};
      4'd2:  r = x + y + {31'd0, cc[8]};
      4'd3:  r = x - y - ex;
      4'd4:  r = 32'd0 - y - ex;
      4'd5:  begin r = x - y - ex; w = 1'b0; end
      4'd6:  r = y;
      4'd7:  r = (x <= y) ? x : y;
      4'd8:  r = ($signed(y) < 0) ? -y : y;
      4'd9:  r = (y > 31) ? 32'd0 : x << y[4:0];
      4'd10: r = (y > 31) ? 32'd0 : x >> y[4:0];
      4'd11: r = (y > 31) ? {32{x[31]}} : $unsigned($signed(x) >>> y[4:0]);
      4'd12: begin p = $unsigned(64'($signed(x)) * 64'($signed(y)));
               r = p[31:0]; hi = p[63:32]; mw = 1'b1; end
      4'd13: begin p = {32'd0, x} * {32'd0, y};
               r = p[31:0]; hi = p[63:32]; mw = 1'b1; end
      default: begin r = '0; w = 1'b0; end
    endcase
    if (sz == 3'd1) r = r & 32'hFF;
    else if (sz == 3'd2) r = r & 32'hFFFF;
  endfunction

  // drive at negedge; comb copy checked 1 ns later, registered copy next negedge
  task automatic run(input logic [3:0] o, input logic [2:0] sz,
                     input logic [W-1:0] x, y, input logic [15:0] cc);
    logic [W-1:0] er, eh, es;
    logic ew, em;
    string t;
    ref_model(o, sz, x, y, cc, er, ew, eh, em, es);
    t = (sz == 3'd1 || sz == 3'd2) ? "R11" : tag_of(o);
    op = o; size = sz; a = x; b = y; ccs = cc; start = 1'b1;
    #1;
    chk(t, "comb result", res_c, er);
    chk(tag_of(o), "comb wb_en", {31'd0, wb_c}, {31'd0, ew});
    chk("R7", "comb mof_we", {31'd0, mwe_c}, {31'd0, em});
    if (em) chk("R7", "comb mof", mof_c, eh);
    chk("R12", "comb src", src_c, es);
    chk("R13", "comb valid", {31'd0, val_c}, 32'd1);
    @(negedge clk);
    chk(t, "reg result", res_r, er);
    chk("R13", "reg wb_en", {31'd0, wb_r}, {31'd0, ew});
    chk("R13", "reg mof_we", {31'd0, mwe_r}, {31'd0, em});
    if (em) chk("R7", "reg mof", mof_r, eh);
    chk("R12", "reg src", src_r, es);
    chk("R13", "reg valid", {31'd0, val_r}, 32'd1);
  endtask

  task automatic idle_check();
    logic [W-1:0] held;
    held = res_r;
    start = 1'b0;
    @(negedge clk);
    chk("R13", "idle valid", {31'd0, val_r}, 32'd0);
    chk("R13", "idle wb_en", {31'd0, wb_r}, 32'd0);
    chk("R13", "idle mof_we", {31'd0, mwe_r}, 32'd0);
    chk("R13", "idle hold", res_r, held);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R13", "reset valid", {31'd0, val_r}, 32'd0);
    chk("R13", "reset result", res_r, 32'd0);
    chk("R13", "reset wb_en", {31'd0, wb_r}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(4'd0, 3'd4, 32'd10, 32'd5, 16'h0001);          // R1 C without X
    run(4'd0, 3'd4, 32'd10, 32'd5, 16'h0011);          // R1 C and X
    run(4'd1, 3'd4, 32'hFFFFFFFF, 32'd1, 16'h0001);    // R2 ADDC
    run(4'd2, 3'd4, 32'd1, 32'd2, 16'h0100);           // R2 R flag
    run(4'd3, 3'd4, 32'd100, 32'd1, 16'h0011);         // R3 SUB borrow
    run(4'd4, 3'd4, 32'd0, 32'd7, 16'h0011);           // R3 NEG
    run(4'd5, 3'd4, 32'd3, 32'd9, 16'h0000);           // R4 CMP
    idle_check();
    run(4'd9, 3'd4, 32'hFFFFFFFF, 32'd31, 16'h0);      // R5 edge
    run(4'd9, 3'd4, 32'hFFFFFFFF, 32'd32, 16'h0);      // R5 over
    run(4'd10, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0);
    run(4'd11, 3'd4, 32'h80000000, 32'd40, 16'h0);     // R6 negative
    run(4'd11, 3'd4, 32'h7FFFFFFF, 32'd40, 16'h0);     // R6 positive
    run(4'd12, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0); // R7 signed
    run(4'd13, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0); // R7 unsigned
    idle_check();
    run(4'd7, 3'd4, 32'd5, 32'd5, 16'h0);              // R8 equal
    run(4'd7, 3'd4, 32'd9, 32'd5, 16'h0);              // R8
    run(4'd8, 3'd4, 32'd0, 32'h80000000, 16'h0);       // R9 corner
    run(4'd8, 3'd4, 32'd0, 32'hFFFFFFF6, 16'h0);       // R9
    run(4'd6, 3'd4, 32'd0, 32'hDEADBEEF, 16'h0);       // R10
    run(4'd6, 3'd1, 32'd0, 32'hDEADBEEF, 16'h0);       // R11 byte
    run(4'd6, 3'd2, 32'd0, 32'hDEADBEEF, 16'h0);       // R11 half
    run(4'd13, 3'd1, 32'h12345678, 32'h9ABCDEF0, 16'h0); // R11 mof unmasked
    run(4'd14, 3'd4, 32'd1, 32'd2, 16'h0);             // R14
    run(4'd15, 3'd4, 32'd1, 32'd2, 16'h0);             // R14
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = ($urandom() % 4 == 0) ? ($urandom() % 40) : $urandom();
      run(4'($urandom()), 3'($urandom()), ra, rb, 16'($urandom()));
      if (i % 50 == 0) idle_check();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule